// File: doc/BRIEF.md
# Dual-Input Proportional Fan PWM Generator

This block drives a fan at a speed proportional to temperature. It takes two unsigned control codes, each a fraction of supply. The larger of the two is mapped through a fixed input window to a duty value. Codes at or below the low edge of the window give a stopped fan. Codes at or above the high edge give a fan that runs all the time. Codes in between give a duty that rises linearly.

A counter produces the PWM timebase. It advances only on cycles where an external clock-enable tick is high. A slow tick stretches the period to the low frequency a fan wants, typically about 30 Hz. A ramp-shape parameter chooses between a sawtooth and a centred triangle. Both shapes have the same number of steps per period.

The duty value and a force-high request are both captured at the start of each period. A change mid-period therefore cannot cut a pulse short. A one-cycle strobe marks the last tick of every period, so an external startup timer can count whole periods. Pulling the enable input low turns the output off and parks the counter at zero.

Top module: `fan_pwm_core`

## Requirements
- R1: The duty value is taken from the larger of `ctl_a` and `ctl_b`. When the two are equal, either one gives the same result.
- R2: With default parameters, a selected code of 77 or less gives 0 high ticks per period.
- R3: A selected code of 179 or more holds `pwm_out` high on all 256 ticks of every period.
- R4: For a selected code m with 77 < m < 179, the number of high ticks per period is floor((m-77)*256/102). This gives 2 for m=78, 62 for m=102, 128 for m=128 and 190 for m=153.
- R5: A period is 256 ticks long, and the counter advances only on cycles where `tick` is high. With a tick on every third cycle, a period is 768 clock cycles.
- R6: `period_done` is high for exactly one cycle per period: the cycle that carries the period's last tick. It is never high on two cycles in a row.
- R7: While `en` is low, `pwm_out` and `period_done` stay low and the counter is held at zero.
- R8: The duty is sampled only at the start of a period. An input change made mid-period does not alter that period's high-tick count.
- R9: If `force_hi` is high at the start of a period, `pwm_out` stays high for the whole period, whatever the control inputs are.
- R10: While reset is asserted, `pwm_out` and `period_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Clock-enable that advances the timebase by one step |
| en | input | 1 | Block enable; when low, the output is off and the counter is held at zero |
| force_hi | input | 1 | Forces the output high for each whole period that starts while it is set |
| ctl_a | input | 8 | First control code; 255 is full supply |
| ctl_b | input | 8 | Second control code; 255 is full supply |
| pwm_out | output | 1 | Fan-drive PWM output, active high |
| period_done | output | 1 | One-cycle strobe on the last tick of each period |

## Verification
The bench counts high ticks over whole periods and compares the total against the window formula. It drives inputs that separate the regions of the mapping: both codes low, a code exactly at each window edge and just inside it, the quarter, half and three-quarter points, and codes above the top edge.

Three patterns check the selection logic: the larger value on either input, and both inputs equal. Two patterns check that the duty is latched per period rather than read continuously: a change partway through a period, and a force request with both inputs at zero.

A tick on every third cycle shows that the period scales with the tick and not with the clock, while the duty count stays the same. An interval with enable low, followed by re-enabling, confirms that the output stays silent and that full periods resume.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;
    localparam int DEF_IN_W   = 8;
    localparam int DEF_CNT_W  = 8;
    localparam int DEF_WIN_LO = 77;
    localparam int DEF_WIN_HI = 179;

    typedef enum logic {
        RAMP_SAW = 1'b0,
        RAMP_TRI = 1'b1
    } ramp_e;
endpackage

// File: rtl/fan_sel_map.sv
module fan_sel_map #(
    parameter int IN_W   = fan_pwm_pkg::DEF_IN_W,
    parameter int CNT_W  = fan_pwm_pkg::DEF_CNT_W,
    parameter int WIN_LO = fan_pwm_pkg::DEF_WIN_LO,
    parameter int WIN_HI = fan_pwm_pkg::DEF_WIN_HI
) (
    input  logic [IN_W-1:0]  ctl_a,
    input  logic [IN_W-1:0]  ctl_b,
    output logic [CNT_W:0]   duty
);
    localparam int PROD_W = IN_W + CNT_W + 1;
    localparam int SPAN   = WIN_HI - WIN_LO;
    localparam logic [CNT_W:0] FULL = (CNT_W+1)'(1) << CNT_W;

    logic [IN_W-1:0]   hot_v;
    logic [IN_W-1:0]   above_lo;
    logic [PROD_W-1:0] scaled;
    logic [PROD_W-1:0] quo;

    always_comb begin
        hot_v    = (ctl_a > ctl_b) ? ctl_a : ctl_b;
        above_lo = hot_v - IN_W'(WIN_LO);
        scaled   = PROD_W'(above_lo) << CNT_W;
        quo      = scaled / PROD_W'(SPAN);
        if (hot_v <= IN_W'(WIN_LO)) begin
            duty = '0;
        end else if (hot_v >= IN_W'(WIN_HI)) begin
            duty = FULL;
        end else begin
            duty = quo[CNT_W:0];
        end
    end
endmodule

// File: rtl/fan_timebase.sv
module fan_timebase #(
    parameter int                 CNT_W = fan_pwm_pkg::DEF_CNT_W,
    parameter fan_pwm_pkg::ramp_e RAMP  = fan_pwm_pkg::RAMP_SAW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    output logic [CNT_W-1:0] phase,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wrap = en && tick && (st_q.cnt == CNT_MAX);

    generate
        if (RAMP == fan_pwm_pkg::RAMP_TRI) begin : g_tri
            always_comb begin
                if (!st_q.cnt[CNT_W-1]) begin
                    phase = {st_q.cnt[CNT_W-2:0], 1'b0};
                end else begin
                    phase = {~st_q.cnt[CNT_W-2:0], 1'b1};
                end
            end
        end else begin : g_saw
            assign phase = st_q.cnt;
        end
    endgenerate

    assert_hold_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st_q.cnt == '0));
    assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick) |=> (st_q.cnt == CNT_W'($past(st_q.cnt) + 1'b1)));
    assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> $stable(st_q.cnt));
endmodule

// File: rtl/fan_cmp.sv
module fan_cmp #(
    parameter int CNT_W = fan_pwm_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             wrap,
    input  logic [CNT_W:0]   duty_in,
    input  logic             force_in,
    input  logic [CNT_W-1:0] phase,
    output logic             pwm
);
    localparam logic [CNT_W:0] FULL = (CNT_W+1)'(1) << CNT_W;

    typedef struct packed {
        logic [CNT_W:0] duty;
        logic           frc;
    } cmp_state_t;

    cmp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wrap || !en) begin
            st_d.duty = duty_in;
            st_d.frc  = force_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm = en && (st_q.frc || ({1'b0, phase} < st_q.duty));

    assert_duty_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !wrap) |=> ($stable(st_q.duty) && $stable(st_q.frc)));
    assert_full_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st_q.duty == FULL) |-> pwm);
    assert_duty_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.duty <= FULL);
endmodule

// File: rtl/fan_pwm_core.sv
module fan_pwm_core #(
    parameter int                 IN_W   = fan_pwm_pkg::DEF_IN_W,
    parameter int                 CNT_W  = fan_pwm_pkg::DEF_CNT_W,
    parameter int                 WIN_LO = fan_pwm_pkg::DEF_WIN_LO,
    parameter int                 WIN_HI = fan_pwm_pkg::DEF_WIN_HI,
    parameter fan_pwm_pkg::ramp_e RAMP   = fan_pwm_pkg::RAMP_SAW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            en,
    input  logic            force_hi,
    input  logic [IN_W-1:0] ctl_a,
    input  logic [IN_W-1:0] ctl_b,
    output logic            pwm_out,
    output logic            period_done
);
    logic [CNT_W:0]   duty_w;
    logic [CNT_W-1:0] phase_w;
    logic             wrap_w;

    fan_sel_map #(
        .IN_W(IN_W), .CNT_W(CNT_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
    ) u_map (
        .ctl_a(ctl_a), .ctl_b(ctl_b), .duty(duty_w)
    );

    fan_timebase #(.CNT_W(CNT_W), .RAMP(RAMP)) u_tb (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(en),
        .phase(phase_w), .wrap(wrap_w)
    );

    fan_cmp #(.CNT_W(CNT_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .en(en), .wrap(wrap_w),
        .duty_in(duty_w), .force_in(force_hi), .phase(phase_w),
        .pwm(pwm_out)
    );

    assign period_done = wrap_w;

    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        period_done |=> !period_done);
    assert_strobe_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        period_done |-> (tick && en));
endmodule

// File: tb/fan_pwm_core_bench.sv
module fan_pwm_core_bench;
    typedef struct {
        int    high;
        int    len;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       en = 1'b0;
    logic       force_hi = 1'b0;
    logic [7:0] ctl_a = 8'd0;
    logic [7:0] ctl_b = 8'd0;
    logic       pwm_out;
    logic       period_done;

    int   n_cmp = 0;
    int   n_bad = 0;
    int   tick_gap = 1;
    int   tick_ph = 0;
    exp_t sb_q[$];

    fan_pwm_core u_fan_pwm_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .force_hi(force_hi),
        .ctl_a(ctl_a), .ctl_b(ctl_b), .pwm_out(pwm_out), .period_done(period_done)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        #1;
        if (tick_gap <= 1) begin
            tick = 1'b1;
        end else begin
            tick = (tick_ph == 0);
            tick_ph = (tick_ph + 1) % tick_gap;
        end
    end

    function automatic int exp_high(input int a, input int b);
        int m;
        m = (a > b) ? a : b;
        if (m <= 77) return 0;
        if (m >= 179) return 256;
        return ((m - 77) * 256) / 102;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: high ticks and clock cycles per period
    int hi_cnt = 0;
    int cyc_cnt = 0;
    bit seen_done = 1'b0;
    always @(negedge clk) begin
        if (!en || !rst_n) begin
            hi_cnt = 0;
            cyc_cnt = 0;
            seen_done = 1'b0;
        end else begin
            cyc_cnt++;
            if (tick && pwm_out) hi_cnt++;
            if (period_done) begin
                if (sb_q.size() > 0 && seen_done) begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check({e.tag, " high ticks"}, hi_cnt, e.high);
                    if (e.len >= 0) check({e.tag, " period length"}, cyc_cnt, e.len);
                end
                hi_cnt = 0;
                cyc_cnt = 0;
                seen_done = 1'b1;
            end
        end
    end

    task automatic wait_done();
        @(negedge clk);
        while (!period_done) @(negedge clk);
        #2;
    endtask

    // apply at a period boundary; the following period is checked
    task automatic apply(input int a, input int b, input bit frc, input int gap,
                         input bit push, input string tag);
        exp_t e;
        wait_done();
        ctl_a = a[7:0];
        ctl_b = b[7:0];
        force_hi = frc;
        tick_gap = gap;
        e.high = frc ? 256 : exp_high(a, b);
        e.len = 256 * gap;
        e.tag = tag;
        if (push) sb_q.push_back(e);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset pwm_out", int'(pwm_out), 0);
        check("R10 reset period_done", int'(period_done), 0);
        en = 1'b1;
        rst_n = 1'b1;
        apply(0, 0, 1'b0, 1, 1'b0, "warmup");
        apply(10, 60, 1'b0, 1, 1'b1, "R2 both low");
        apply(77, 0, 1'b0, 1, 1'b1, "R2 at low edge");
        apply(78, 0, 1'b0, 1, 1'b1, "R4 just above low");
        apply(102, 20, 1'b0, 1, 1'b1, "R4 quarter a");
        apply(102, 128, 1'b0, 1, 1'b1, "R1 b larger");
        apply(153, 0, 1'b0, 1, 1'b1, "R4 three quarter");
        apply(140, 140, 1'b0, 1, 1'b1, "R1 equal");
        apply(178, 0, 1'b0, 1, 1'b1, "R4 just below high");
        apply(0, 179, 1'b0, 1, 1'b1, "R3 at high edge");
        apply(230, 5, 1'b0, 1, 1'b1, "R3 above window");
        apply(0, 0, 1'b1, 1, 1'b1, "R9 force high");
        apply(128, 0, 1'b0, 1, 1'b1, "R8 pre-change");
        repeat (100) @(negedge clk);
        #2;
        ctl_a = 8'd240;
        force_hi = 1'b1;
        repeat (50) @(negedge clk);
        #2;
        force_hi = 1'b0;
        apply(102, 0, 1'b0, 3, 1'b0, "gap switch");
        apply(102, 0, 1'b0, 3, 1'b1, "R5 tick every third");
        apply(153, 0, 1'b0, 3, 1'b1, "R5 tick every third b");
        apply(128, 0, 1'b0, 1, 1'b0, "gap back");
        wait_done();
        // R7: enable low silences output and strobe
        en = 1'b0;
        ctl_a = 8'd220;
        begin
            int hits;
            hits = 0;
            for (int i = 0; i < 600; i++) begin
                @(negedge clk);
                if (pwm_out || period_done) hits++;
            end
            check("R7 disabled output and strobe", hits, 0);
        end
        #2;
        en = 1'b1;
        apply(220, 0, 1'b0, 1, 1'b0, "re-enable");
        apply(128, 0, 1'b0, 1, 1'b1, "R6 R7 resume after enable");
        wait_done();
        check("R8 R6 scoreboard drained", sb_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule